// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block takes the configuration writes that a host issues to an interrupt controller after power-up. It steps through them in a fixed order: a start word, a vector-base word, a cascade-map word when the controller is one of several, and a mode word when the start word asks for one. After the last required word it raises `ready`, which tells the rest of the controller that request handling may begin. A new start word is accepted in any state and restarts the sequence.

The block holds the configuration fields from the writes and drives them as decoded outputs. These outputs are trigger type, vector interval, single or cascaded operation, whether a mode word was requested, special nested mode, buffered mode, master role, automatic end-of-interrupt and processor mode. The host side is a write strobe, one address bit and an 8-bit data bus. Priority resolution, the request and in-service registers, and the command words used after initialization belong to other blocks.

Top module: `intc_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after reset, `ready` and every configuration output are 0.
- R2: A write with `addr0`=0 and `wr_data[4]`=1 is a start word. It is taken in any state and restarts the sequence, so `ready` is 0 in the next cycle. It loads `cfg_mode_word_present` from bit 0, `cfg_single` from bit 1, `cfg_interval4` from bit 2 and `cfg_level_trig` from bit 3. It clears the vector base, the cascade map and all mode-word outputs.
- R3: The first write with `addr0`=1 after a start word loads `vec_base` from `wr_data`.
- R4: When `cfg_single`=0, the next `addr0`=1 write after the vector base loads `cascade_map`. When `cfg_single`=1, no cascade word is expected and `cascade_map` stays 0.
- R5: When a mode word is expected, the next `addr0`=1 write loads it. Bit 0 gives `cfg_vector_mode`, bit 1 gives `cfg_auto_eoi`, bit 2 is the master/slave bit, bit 3 gives `cfg_buffered` and bit 4 gives `cfg_special_nested`.
- R6: When the start word has bit 0 = 0, no mode word is expected. `cfg_vector_mode`, `cfg_auto_eoi`, `cfg_buffered`, `cfg_special_nested` and `cfg_master` are all 0 once `ready` is 1.
- R7: `ready` goes to 1 in the cycle after the last required word is written. It stays 1 until the next start word or reset.
- R8: `cfg_master` is 1 only when `cfg_buffered` is 1 and the master/slave bit of the mode word was 1. When not buffered, that bit has no effect.
- R9: The following writes change no output: a write with `addr0`=0 and `wr_data[4]`=0, a write with `addr0`=1 while `ready` is 1 or before any start word, and any cycle with `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle when high |
| addr0 | input | 1 | Address bit selecting the start word (0) or a following word (1) |
| wr_data | input | 8 | Write data |
| ready | output | 1 | Initialization complete, requests may be accepted |
| cfg_level_trig | output | 1 | Level-sensitive requests; edge detection disabled |
| cfg_interval4 | output | 1 | 1 = 4-location vector interval, 0 = 8-location |
| cfg_single | output | 1 | Single controller, no cascade word |
| cfg_mode_word_present | output | 1 | Start word requested a mode word |
| cfg_special_nested | output | 1 | Special fully nested mode |
| cfg_buffered | output | 1 | Buffered mode |
| cfg_master | output | 1 | Master role (buffered mode only) |
| cfg_auto_eoi | output | 1 | Automatic end-of-interrupt |
| cfg_vector_mode | output | 1 | 1 = vector system, 0 = byte-call system |
| vec_base | output | 8 | Vector base word |
| cascade_map | output | 8 | Cascade word |

## Verification
Every output is a register. A write presented before a rising edge therefore shows on `ready` and on the configuration outputs right after that edge, one cycle of latency. There are no longer paths. The bench drives writes on the falling edge. Its reference model updates on the rising edge from a queue of the words still expected. All outputs are compared with the model on the next falling edge, so each result is sampled exactly in the cycle it becomes due. Ignored writes are checked by this same per-cycle comparison, which confirms the outputs held in the cycle after each one.

// File: rtl/intc_init_pkg.sv
// Package: shared types and field positions for the initialization sequencer.
// Assumes the start word and mode word share the low five data bits.
package intc_init_pkg;

    // Start word: bit 4 marks a start word; bits 3..0 carry the fields.
    localparam int SW_NEED_MODE = 0;
    localparam int SW_SINGLE    = 1;
    localparam int SW_INTERVAL  = 2;
    localparam int SW_LEVEL     = 3;
    localparam int SW_MARK      = 4;

    // Mode word field positions.
    localparam int MW_VECTOR    = 0;
    localparam int MW_AEOI      = 1;
    localparam int MW_MASTER    = 2;
    localparam int MW_BUFFERED  = 3;
    localparam int MW_NESTED    = 4;

    localparam int FIELD_BITS   = 5;

    typedef enum logic [2:0] {
        ST_UNINIT    = 3'd0,
        ST_WAIT_BASE = 3'd1,
        ST_WAIT_CASC = 3'd2,
        ST_WAIT_MODE = 3'd3,
        ST_READY     = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic level;
        logic interval4;
        logic single;
        logic need_mode;
    } start_fields_t;

    typedef struct packed {
        logic nested;
        logic buffered;
        logic master_bit;
        logic aeoi;
        logic vector;
    } mode_fields_t;

endpackage

// File: rtl/intc_word_decode.sv
// Module: classifies a bus write and unpacks the low data bits into
// start-word and mode-word fields. Purely combinational.
// Assumes the caller passes only the low FIELD_BITS of the data bus.
module intc_word_decode
    import intc_init_pkg::*;
(
    input  logic                  wr_en,
    input  logic                  addr0,
    input  logic [FIELD_BITS-1:0] field_bits,
    output logic                  is_start,
    output logic                  is_follow,
    output start_fields_t         start_f,
    output mode_fields_t          mode_f
);

    // Write classification: start word needs the mark bit; others use addr0=1.
    always_comb begin
        is_start  = wr_en && !addr0 && field_bits[SW_MARK];
        is_follow = wr_en && addr0;
    end

    // Field unpacking by named position.
    always_comb begin
        start_f.need_mode = field_bits[SW_NEED_MODE];
        start_f.single    = field_bits[SW_SINGLE];
        start_f.interval4 = field_bits[SW_INTERVAL];
        start_f.level     = field_bits[SW_LEVEL];
        mode_f.vector     = field_bits[MW_VECTOR];
        mode_f.aeoi       = field_bits[MW_AEOI];
        mode_f.master_bit = field_bits[MW_MASTER];
        mode_f.buffered   = field_bits[MW_BUFFERED];
        mode_f.nested     = field_bits[MW_NESTED];
    end

endmodule

// File: rtl/intc_seq_fsm.sv
// Module: sequence state machine. Steps start -> base -> [cascade] ->
// [mode] -> ready and issues one load strobe per accepted word.
// Assumes single/need_mode come from the held start-word fields.
module intc_seq_fsm
    import intc_init_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_start,
    input  logic       is_follow,
    input  logic       held_single,
    input  logic       held_need_mode,
    output logic       load_start,
    output logic       load_base,
    output logic       load_casc,
    output logic       load_mode,
    output logic       ready
);

    seq_state_t state_q;
    seq_state_t state_d;
    seq_state_t after_casc;

    // Destination once cascade handling is done: mode word or ready.
    always_comb begin
        after_casc = held_need_mode ? ST_WAIT_MODE : ST_READY;
    end

    // Next-state and load-strobe decode.
    always_comb begin
        state_d    = state_q;
        load_start = 1'b0;
        load_base  = 1'b0;
        load_casc  = 1'b0;
        load_mode  = 1'b0;
        if (is_start) begin
            load_start = 1'b1;
            state_d    = ST_WAIT_BASE;
        end else if (is_follow) begin
            unique case (state_q)
                ST_WAIT_BASE: begin
                    load_base = 1'b1;
                    state_d   = held_single ? after_casc : ST_WAIT_CASC;
                end
                ST_WAIT_CASC: begin
                    load_casc = 1'b1;
                    state_d   = after_casc;
                end
                ST_WAIT_MODE: begin
                    load_mode = 1'b1;
                    state_d   = ST_READY;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    // Ready flag derived from the registered state.
    always_comb begin
        ready = (state_q == ST_READY);
    end

endmodule

// File: rtl/intc_cfg_regs.sv
// Module: configuration holding registers. Loads each word's fields on
// its strobe; a start word clears everything loaded by later words.
// Assumes at most one load strobe is active per cycle.
module intc_cfg_regs
    import intc_init_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              load_base,
    input  logic              load_casc,
    input  logic              load_mode,
    input  start_fields_t     start_f,
    input  mode_fields_t      mode_f,
    input  logic [DATA_W-1:0] data,
    output start_fields_t     start_q,
    output mode_fields_t      mode_q,
    output logic [DATA_W-1:0] base_q,
    output logic [N_LINES-1:0] casc_q
);

    // Start-word fields: loaded only by a start word.
    always_ff @(posedge clk) begin
        if (!rst_n)          start_q <= '0;
        else if (load_start) start_q <= start_f;
    end

    // Mode-word fields: cleared by a start word so a skipped word leaves 0.
    always_ff @(posedge clk) begin
        if (!rst_n || load_start) mode_q <= '0;
        else if (load_mode)       mode_q <= mode_f;
    end

    // Vector base word.
    always_ff @(posedge clk) begin
        if (!rst_n || load_start) base_q <= '0;
        else if (load_base)       base_q <= data;
    end

    // Cascade map: one flop per request line.
    for (genvar i = 0; i < N_LINES; i++) begin : g_casc
        // Per-line cascade bit, cleared by a start word.
        always_ff @(posedge clk) begin
            if (!rst_n || load_start) casc_q[i] <= 1'b0;
            else if (load_casc)       casc_q[i] <= data[i];
        end
    end

endmodule

// File: rtl/intc_init_seq.sv
// Module: top of the initialization sequencer. Joins the write decoder,
// the sequence FSM and the holding registers and drives decoded fields.
// Assumes N_LINES <= DATA_W and DATA_W >= FIELD_BITS.
module intc_init_seq
    import intc_init_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               addr0,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               ready,
    output logic               cfg_level_trig,
    output logic               cfg_interval4,
    output logic               cfg_single,
    output logic               cfg_mode_word_present,
    output logic               cfg_special_nested,
    output logic               cfg_buffered,
    output logic               cfg_master,
    output logic               cfg_auto_eoi,
    output logic               cfg_vector_mode,
    output logic [DATA_W-1:0]  vec_base,
    output logic [N_LINES-1:0] cascade_map
);

    logic          is_start, is_follow;
    logic          load_start, load_base, load_casc, load_mode;
    start_fields_t start_f, start_q;
    mode_fields_t  mode_f, mode_q;

    intc_word_decode u_dec (
        .wr_en      (wr_en),
        .addr0      (addr0),
        .field_bits (wr_data[FIELD_BITS-1:0]),
        .is_start   (is_start),
        .is_follow  (is_follow),
        .start_f    (start_f),
        .mode_f     (mode_f)
    );

    intc_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .is_start       (is_start),
        .is_follow      (is_follow),
        .held_single    (start_q.single),
        .held_need_mode (start_q.need_mode),
        .load_start     (load_start),
        .load_base      (load_base),
        .load_casc      (load_casc),
        .load_mode      (load_mode),
        .ready          (ready)
    );

    intc_cfg_regs #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .load_base  (load_base),
        .load_casc  (load_casc),
        .load_mode  (load_mode),
        .start_f    (start_f),
        .mode_f     (mode_f),
        .data       (wr_data),
        .start_q    (start_q),
        .mode_q     (mode_q),
        .base_q     (vec_base),
        .casc_q     (cascade_map)
    );

    // Output decode; role bit only counts in buffered mode.
    always_comb begin
        cfg_level_trig        = start_q.level;
        cfg_interval4         = start_q.interval4;
        cfg_single            = start_q.single;
        cfg_mode_word_present = start_q.need_mode;
        cfg_special_nested    = mode_q.nested;
        cfg_buffered          = mode_q.buffered;
        cfg_master            = mode_q.buffered && mode_q.master_bit;
        cfg_auto_eoi          = mode_q.aeoi;
        cfg_vector_mode       = mode_q.vector;
    end

endmodule

// File: rtl/intc_init_seq_chk.sv
// Module: assertion checker for the initialization sequencer, bound to
// the top. Observes ports only.
module intc_init_seq_chk #(
    parameter int DATA_W  = 8,
    parameter int N_LINES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               addr0,
    input logic [DATA_W-1:0]  wr_data,
    input logic               ready,
    input logic               cfg_level_trig,
    input logic               cfg_interval4,
    input logic               cfg_single,
    input logic               cfg_mode_word_present,
    input logic               cfg_special_nested,
    input logic               cfg_buffered,
    input logic               cfg_master,
    input logic               cfg_auto_eoi,
    input logic               cfg_vector_mode,
    input logic [DATA_W-1:0]  vec_base,
    input logic [N_LINES-1:0] cascade_map
);

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr0 && wr_data[4]) |=> !ready);

    p_start_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr0 && wr_data[4]) |=>
        (cfg_mode_word_present == $past(wr_data[0]) && cfg_single == $past(wr_data[1])
         && cfg_interval4 == $past(wr_data[2]) && cfg_level_trig == $past(wr_data[3])));

    p_single_no_cascade_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_single) |-> (cascade_map == '0));

    p_skip_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cfg_mode_word_present) |->
        (!cfg_buffered && !cfg_auto_eoi && !cfg_vector_mode && !cfg_special_nested && !cfg_master));

    p_ready_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(wr_en && addr0));

    p_master_buffered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master |-> cfg_buffered);

    p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(wr_en && !addr0 && wr_data[4])) |=>
        (ready && $stable(vec_base) && $stable(cascade_map) && $stable(cfg_buffered)
         && $stable(cfg_master) && $stable(cfg_auto_eoi) && $stable(cfg_vector_mode)));

endmodule

bind intc_init_seq intc_init_seq_chk #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_chk (.*);

// File: tb/intc_init_seq_test.sv
// Bench: behavioural reference model (queue of words still expected),
// compared with every output on each falling edge.
module intc_init_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr0 = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ready, cfg_level_trig, cfg_interval4, cfg_single, cfg_mode_word_present;
    logic       cfg_special_nested, cfg_buffered, cfg_master, cfg_auto_eoi, cfg_vector_mode;
    logic [7:0] vec_base, cascade_map;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    intc_init_seq uut (.*);

    always #5 clk = ~clk;

    // Reference model state.
    int   pending[$];
    bit   m_init;
    bit   m_level, m_int4, m_single, m_need;
    bit   m_vec, m_aeoi, m_ms, m_buf, m_nest;
    int   m_base, m_casc;

    always @(posedge clk) begin
        if (!rst_n) begin
            pending.delete();
            m_init = 0;
            {m_level, m_int4, m_single, m_need} = '0;
            {m_vec, m_aeoi, m_ms, m_buf, m_nest} = '0;
            m_base = 0; m_casc = 0;
        end else if (wr_en) begin
            if (!addr0 && wr_data[4]) begin
                pending.delete();
                m_init   = 1;
                m_need   = wr_data[0];
                m_single = wr_data[1];
                m_int4   = wr_data[2];
                m_level  = wr_data[3];
                {m_vec, m_aeoi, m_ms, m_buf, m_nest} = '0;
                m_base = 0; m_casc = 0;
                pending.push_back(2);
                if (!m_single) pending.push_back(3);
                if (m_need) pending.push_back(4);
            end else if (addr0 && pending.size() > 0) begin
                int kind;
                kind = pending.pop_front();
                if (kind == 2) m_base = int'(wr_data);
                else if (kind == 3) m_casc = int'(wr_data);
                else begin
                    m_vec  = wr_data[0];
                    m_aeoi = wr_data[1];
                    m_ms   = wr_data[2];
                    m_buf  = wr_data[3];
                    m_nest = wr_data[4];
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            chk("R7 ready", int'(ready), int'(m_init && pending.size() == 0));
            chk("R2 level", int'(cfg_level_trig), int'(m_level));
            chk("R2 interval", int'(cfg_interval4), int'(m_int4));
            chk("R2 single", int'(cfg_single), int'(m_single));
            chk("R2 need_mode", int'(cfg_mode_word_present), int'(m_need));
            chk("R3 base", int'(vec_base), m_base);
            chk("R4 cascade", int'(cascade_map), m_casc);
            chk("R5 vector", int'(cfg_vector_mode), int'(m_vec));
            chk("R5 aeoi", int'(cfg_auto_eoi), int'(m_aeoi));
            chk("R5 nested", int'(cfg_special_nested), int'(m_nest));
            chk("R5 buffered", int'(cfg_buffered), int'(m_buf));
            chk("R8 master", int'(cfg_master), int'(m_buf && m_ms));
        end
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr0 = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'hA5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(posedge clk);
        #1;
        // R1: reset state, explicit.
        chk("R1 ready", int'(ready), 0);
        chk("R1 cfg", int'({cfg_level_trig, cfg_single, cfg_buffered, cfg_master}), 0);
        // R9: follow-word before any start word is ignored.
        wr(1'b1, 8'h77);
        // Single, no mode word: R6 defaults.
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h40);
        chk("R6 ready after base", int'(ready), 1);
        // Cascade and mode word, buffered master.
        wr(1'b0, 8'h1D);
        wr(1'b1, 8'h48);
        chk("R4 not ready yet", int'(ready), 0);
        wr(1'b1, 8'h0F);
        wr(1'b1, 8'h1F);
        chk("R8 master", int'(cfg_master), 1);
        // R9: ignored writes in ready state.
        wr(1'b0, 8'h0B);
        wr(1'b1, 8'hFF);
        @(negedge clk);
        wr_data = 8'h13;
        @(negedge clk);
        chk("R9 still ready", int'(ready), 1);
        // Not buffered: master bit ignored (R8).
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h05);
        chk("R8 unbuffered master", int'(cfg_master), 0);
        // Restart mid-sequence (R2).
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h20);
        wr(1'b0, 8'h1F);
        chk("R2 restart", int'(ready), 0);
        wr(1'b1, 8'h30);
        wr(1'b1, 8'h0A);
        chk("R5 single mode word ready", int'(ready), 1);
        chk("R5 aeoi", int'(cfg_auto_eoi), 1);
        // Back-to-back writes without idle cycles.
        @(negedge clk);
        wr_en = 1'b1; addr0 = 1'b0; wr_data = 8'h10;
        @(negedge clk);
        addr0 = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        addr0 = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 back-to-back ready", int'(ready), 1);
        chk("R4 back-to-back cascade", int'(cascade_map), 8'h3C);
        // Reset mid-operation (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", int'(ready || vec_base != 0), 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule